// File: doc/BRIEF.md
# UART Register File and Interrupt Encoder

This block is the software-visible face of a simple serial port that sends and receives only 8N1 frames: one start bit, eight data bits, no parity and one stop bit. It is a byte-wide bus slave with sixteen register slots selected by a 4-bit offset. Offset 0 is shared. A write there pushes a byte toward the transmit buffer, and a read there pops the byte at the head of the receive buffer. The other offsets hold the following:

- line and modem status
- an encoded interrupt status
- interrupt enables
- modem and flow control bits
- the four bytes of the baud synthesizer multiplier
- two inert storage bytes kept for compatibility (frame format and FIFO control)
- a scratch byte

The transmit and receive buffers, the shifters and the baud generator sit outside this block. They connect through single-cycle push and pop strobes and level status inputs. Modem inputs arrive as active-high levels that are already synchronized.

Three interrupt sources are gated by their enable bits. These are a change on the carrier-detect line, receive data present and transmitter empty. The enabled sources are reduced to one prioritized code, which is registered together with a pending flag. The same pending flag drives the interrupt request output.

Top module: `uart_regfile`

## Requirements
- R1: After reset, the following values hold:
  - ack, vol, tx_push, rx_pop and irq are 0.
  - dtr_o equals RST_DTR and rts_o equals RST_RTS (both default 1).
  - hw_flow_o is 0.
  - mul_o equals RST_MUL.
  - Interrupt enable reads 0x00.
- R2: Each strobed cycle (cyc and stb high while ack is low) produces ack high in the following cycle. Ack is never high for two cycles in a row. Read data and vol are valid in the ack cycle.
- R3: A write to offset 0 while tx_full is low pulses tx_push in the ack cycle, with tx_data equal to the written byte. While tx_full is high the byte is dropped and tx_push stays low.
- R4: A read of offset 0 while rx_avail is high returns rx_data and pulses rx_pop in the ack cycle. While rx_avail is low it returns the last byte popped (0x00 after reset), and rx_pop stays low.
- R5: Offset 1 reads the line status. All other bits read 0. The set bits are:
  - bit 0: rx_avail
  - bit 1: rx_overrun
  - bit 3: rx_frame_err
  - bit 5: not tx_full
  - bit 6: tx_empty
- R6: Offset 2 reads the modem status. Bits 0 to 2 read 0. The set bits are:
  - bit 3: sticky carrier-change flag
  - bit 4: cts
  - bit 5: dsr
  - bit 6: ri
  - bit 7: dcd

  The change flag is set in the cycle after dcd changes level. Any write to offset 2 clears it.
- R7: Offset 3 reads the interrupt status as {pending, 2'b00, code[2:0], 2'b00}. The source code is chosen by priority:
  - 3 for a carrier change enabled by IE bit 3
  - 2 for receive data enabled by IE bit 0
  - 1 for transmitter empty enabled by IE bit 1

  With no enabled source active, the byte reads 0x00.
- R8: irq is registered. It equals 1 in the cycle after any enabled source is active, and it matches bit 7 of the interrupt status.
- R9: Offset 4 stores only IE bits 0, 1 and 3, so reading it returns the written byte masked with 0x0B.
- R10: Offset 6 bit 0 drives dtr_o and bit 1 drives rts_o. It reads back as those two bits. Offset 7 bit 0 drives hw_flow_o and reads back as that bit.
- R11: Offsets 8 to 11 are multiplier bytes 0 to 3, least significant first. mul_o equals {byte3, byte2, byte1, byte0}, and each byte reads back as written.
- R12: Offsets 5, 12 and 15 are full 8-bit storage that reads back as written and changes no output. Offsets 13 and 14 read 0x00, and writes to them change nothing.
- R13: vol is high together with ack for reads of offsets 0, 1 and 2, and low for writes and for reads of any other offset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cyc | input | 1 | Bus cycle valid |
| stb | input | 1 | Bus strobe |
| we | input | 1 | 1 = write, 0 = read |
| adr | input | 4 | Register offset |
| wdat | input | 8 | Write data |
| rdat | output | 8 | Read data, valid with ack |
| ack | output | 1 | Transfer acknowledge |
| vol | output | 1 | Volatile register read indication |
| irq | output | 1 | Interrupt request |
| tx_push | output | 1 | Push strobe to the transmit buffer |
| tx_data | output | 8 | Byte pushed to the transmit buffer |
| tx_full | input | 1 | Transmit buffer cannot accept data |
| tx_empty | input | 1 | Transmitter completely idle and empty |
| rx_pop | output | 1 | Pop strobe to the receive buffer |
| rx_data | input | 8 | Byte at the head of the receive buffer |
| rx_avail | input | 1 | Receive buffer holds data |
| rx_overrun | input | 1 | Receiver overrun occurred |
| rx_frame_err | input | 1 | Head byte has a framing error |
| cts | input | 1 | Clear-to-send level |
| dsr | input | 1 | Data-set-ready level |
| ri | input | 1 | Ring-indicator level |
| dcd | input | 1 | Carrier-detect level |
| dtr_o | output | 1 | Data-terminal-ready level |
| rts_o | output | 1 | Request-to-send level |
| hw_flow_o | output | 1 | Hardware flow control enable |
| mul_o | output | 32 | Baud synthesizer multiplier |

## Verification
The checker watches four things on every cycle:
- the handshake: one ack per strobed cycle, never two in a row, and vol only with ack
- that push and pop strobes occur only in an ack cycle and only when the buffer allowed them
- that irq follows the enabled sources with one cycle of delay
- that a carrier edge always sets the change flag

The bench scenarios cover the rest:
- the bit placement of the status bytes and the source priority of the encoded code
- the mask on the enable register
- the last-byte return on an empty receive buffer
- the ordering of the multiplier bytes
- that the inert and reserved offsets leave the outputs untouched

// File: rtl/uart_rf_pkg.sv
package uart_rf_pkg;
  localparam int BYTE_W = 8;
  localparam int ADR_W  = 4;
  localparam int NREG   = 1 << ADR_W;
  localparam int MUL_BYTES = 4;
  localparam int MUL_W  = MUL_BYTES * BYTE_W;

  typedef enum logic [ADR_W-1:0] {
    OFS_DATA    = 4'd0,
    OFS_LINE    = 4'd1,
    OFS_MODEM   = 4'd2,
    OFS_ISTAT   = 4'd3,
    OFS_IEN     = 4'd4,
    OFS_FRAME   = 4'd5,
    OFS_MCTL    = 4'd6,
    OFS_CTRL    = 4'd7,
    OFS_MUL0    = 4'd8,
    OFS_MUL1    = 4'd9,
    OFS_MUL2    = 4'd10,
    OFS_MUL3    = 4'd11,
    OFS_FCTL    = 4'd12,
    OFS_RSV0    = 4'd13,
    OFS_RSV1    = 4'd14,
    OFS_SCRATCH = 4'd15
  } reg_ofs_e;

  // enable bit positions
  localparam int EN_RX = 0;
  localparam int EN_TX = 1;
  localparam int EN_MS = 3;
  localparam logic [BYTE_W-1:0] EN_MASK = 8'h0B;

  // interrupt source codes, higher wins
  localparam logic [2:0] SRC_NONE = 3'd0;
  localparam logic [2:0] SRC_TX   = 3'd1;
  localparam logic [2:0] SRC_RX   = 3'd2;
  localparam logic [2:0] SRC_MS   = 3'd3;
endpackage

// File: rtl/uart_rf_bus.sv
module uart_rf_bus
  import uart_rf_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             cyc,
  input  logic             stb,
  input  logic             we,
  input  logic [ADR_W-1:0] adr,
  output logic             req_rd,
  output logic             req_wr,
  output logic [NREG-1:0]  wr_sel,
  output logic             ack
);
  logic req;

  assign req    = cyc & stb & ~ack;
  assign req_rd = req & ~we;
  assign req_wr = req & we;

  for (genvar g = 0; g < NREG; g++) begin : g_wsel
    assign wr_sel[g] = req_wr && (adr == ADR_W'(g));
  end

  always_ff @(posedge clk) begin
    if (rst) ack <= 1'b0;
    else     ack <= req;
  end
endmodule

// File: rtl/uart_rf_modem.sv
module uart_rf_modem
  import uart_rf_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              cts,
  input  logic              dsr,
  input  logic              ri,
  input  logic              dcd,
  input  logic              clr_chg,
  output logic              dcd_chg,
  output logic [BYTE_W-1:0] ms_byte
);
  logic dcd_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      dcd_q   <= dcd;
      dcd_chg <= 1'b0;
    end else begin
      dcd_q <= dcd;
      if (dcd != dcd_q)  dcd_chg <= 1'b1;
      else if (clr_chg)  dcd_chg <= 1'b0;
    end
  end

  assign ms_byte = {dcd, ri, dsr, cts, dcd_chg, 3'b000};
endmodule

// File: rtl/uart_rf_irq.sv
module uart_rf_irq
  import uart_rf_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       en_rx,
  input  logic       en_tx,
  input  logic       en_ms,
  input  logic       src_rx,
  input  logic       src_tx,
  input  logic       src_ms,
  output logic       pend,
  output logic [2:0] code
);
  logic hit_rx, hit_tx, hit_ms;

  assign hit_rx = en_rx & src_rx;
  assign hit_tx = en_tx & src_tx;
  assign hit_ms = en_ms & src_ms;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend <= 1'b0;
      code <= SRC_NONE;
    end else begin
      pend <= hit_rx | hit_tx | hit_ms;
      if (hit_ms)      code <= SRC_MS;
      else if (hit_rx) code <= SRC_RX;
      else if (hit_tx) code <= SRC_TX;
      else             code <= SRC_NONE;
    end
  end
endmodule

// File: rtl/uart_regfile.sv
module uart_regfile
  import uart_rf_pkg::*;
#(
  parameter logic [31:0] RST_MUL = 32'h0257_C000,
  parameter bit          RST_DTR = 1'b1,
  parameter bit          RST_RTS = 1'b1
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        cyc,
  input  logic        stb,
  input  logic        we,
  input  logic [3:0]  adr,
  input  logic [7:0]  wdat,
  output logic [7:0]  rdat,
  output logic        ack,
  output logic        vol,
  output logic        irq,
  output logic        tx_push,
  output logic [7:0]  tx_data,
  input  logic        tx_full,
  input  logic        tx_empty,
  output logic        rx_pop,
  input  logic [7:0]  rx_data,
  input  logic        rx_avail,
  input  logic        rx_overrun,
  input  logic        rx_frame_err,
  input  logic        cts,
  input  logic        dsr,
  input  logic        ri,
  input  logic        dcd,
  output logic        dtr_o,
  output logic        rts_o,
  output logic        hw_flow_o,
  output logic [31:0] mul_o
);
  logic              req_rd, req_wr;
  logic [NREG-1:0]   wr_sel;
  logic [BYTE_W-1:0] ie_q, frame_q, fctl_q, scratch_q, last_rx_q;
  logic [BYTE_W-1:0] ms_byte, ls_byte, is_byte, rd_mux;
  logic [MUL_W-1:0]  mul_q;
  logic              dcd_chg, pend;
  logic [2:0]        code;

  uart_rf_bus bus_i (
    .clk(clk), .rst(rst), .cyc(cyc), .stb(stb), .we(we), .adr(adr),
    .req_rd(req_rd), .req_wr(req_wr), .wr_sel(wr_sel), .ack(ack)
  );

  uart_rf_modem modem_i (
    .clk(clk), .rst(rst), .cts(cts), .dsr(dsr), .ri(ri), .dcd(dcd),
    .clr_chg(wr_sel[OFS_MODEM]), .dcd_chg(dcd_chg), .ms_byte(ms_byte)
  );

  uart_rf_irq irq_i (
    .clk(clk), .rst(rst),
    .en_rx(ie_q[EN_RX]), .en_tx(ie_q[EN_TX]), .en_ms(ie_q[EN_MS]),
    .src_rx(rx_avail), .src_tx(tx_empty), .src_ms(dcd_chg),
    .pend(pend), .code(code)
  );

  assign irq = pend;

  // multiplier bytes, least significant at the lowest offset
  for (genvar b = 0; b < MUL_BYTES; b++) begin : g_mul
    always_ff @(posedge clk) begin
      if (rst)
        mul_q[b*BYTE_W +: BYTE_W] <= RST_MUL[b*BYTE_W +: BYTE_W];
      else if (wr_sel[int'(OFS_MUL0) + b])
        mul_q[b*BYTE_W +: BYTE_W] <= wdat;
    end
  end
  assign mul_o = mul_q;

  // control and storage registers
  always_ff @(posedge clk) begin
    if (rst) begin
      ie_q      <= '0;
      frame_q   <= '0;
      fctl_q    <= '0;
      scratch_q <= '0;
      dtr_o     <= RST_DTR;
      rts_o     <= RST_RTS;
      hw_flow_o <= 1'b0;
    end else begin
      if (wr_sel[OFS_IEN])     ie_q      <= wdat & EN_MASK;
      if (wr_sel[OFS_FRAME])   frame_q   <= wdat;
      if (wr_sel[OFS_FCTL])    fctl_q    <= wdat;
      if (wr_sel[OFS_SCRATCH]) scratch_q <= wdat;
      if (wr_sel[OFS_MCTL]) begin
        dtr_o <= wdat[0];
        rts_o <= wdat[1];
      end
      if (wr_sel[OFS_CTRL])    hw_flow_o <= wdat[0];
    end
  end

  assign ls_byte = {1'b0, tx_empty, ~tx_full, 1'b0, rx_frame_err, 1'b0, rx_overrun, rx_avail};
  assign is_byte = {pend, 2'b00, code, 2'b00};

  always_comb begin
    unique case (reg_ofs_e'(adr))
      OFS_DATA:    rd_mux = rx_avail ? rx_data : last_rx_q;
      OFS_LINE:    rd_mux = ls_byte;
      OFS_MODEM:   rd_mux = ms_byte;
      OFS_ISTAT:   rd_mux = is_byte;
      OFS_IEN:     rd_mux = ie_q;
      OFS_FRAME:   rd_mux = frame_q;
      OFS_MCTL:    rd_mux = {6'b0, rts_o, dtr_o};
      OFS_CTRL:    rd_mux = {7'b0, hw_flow_o};
      OFS_MUL0:    rd_mux = mul_q[7:0];
      OFS_MUL1:    rd_mux = mul_q[15:8];
      OFS_MUL2:    rd_mux = mul_q[23:16];
      OFS_MUL3:    rd_mux = mul_q[31:24];
      OFS_FCTL:    rd_mux = fctl_q;
      OFS_SCRATCH: rd_mux = scratch_q;
      default:     rd_mux = '0;
    endcase
  end

  // registered bus-side outputs, aligned with ack
  always_ff @(posedge clk) begin
    if (rst) begin
      rdat      <= '0;
      vol       <= 1'b0;
      tx_push   <= 1'b0;
      tx_data   <= '0;
      rx_pop    <= 1'b0;
      last_rx_q <= '0;
    end else begin
      vol     <= req_rd && (adr <= 4'd2);
      tx_push <= wr_sel[OFS_DATA] && !tx_full;
      rx_pop  <= req_rd && (adr == OFS_DATA) && rx_avail;
      if (req_rd) rdat <= rd_mux;
      if (wr_sel[OFS_DATA] && !tx_full) tx_data <= wdat;
      if (req_rd && (adr == OFS_DATA) && rx_avail) last_rx_q <= rx_data;
    end
  end
endmodule

// File: rtl/uart_regfile_chk.sv
module uart_regfile_chk (
  input logic       clk,
  input logic       rst,
  input logic       cyc,
  input logic       stb,
  input logic       we,
  input logic       ack,
  input logic       vol,
  input logic       tx_push,
  input logic       tx_full,
  input logic       tx_empty,
  input logic       rx_pop,
  input logic       rx_avail,
  input logic       irq,
  input logic       dcd,
  input logic       dcd_chg,
  input logic [7:0] ie_q
);
  logic any_src;
  assign any_src = (ie_q[0] & rx_avail) | (ie_q[1] & tx_empty) | (ie_q[3] & dcd_chg);

  // R2
  ack_single_chk: assert property (@(posedge clk) disable iff (rst) ack |=> !ack);
  // R2
  ack_follow_chk: assert property (@(posedge clk) disable iff (rst) (cyc && stb && !ack) |=> ack);
  // R3
  push_ok_chk: assert property (@(posedge clk) disable iff (rst) tx_push |-> (ack && $past(!tx_full) && $past(we)));
  // R4
  pop_ok_chk: assert property (@(posedge clk) disable iff (rst) rx_pop |-> (ack && $past(rx_avail) && $past(!we)));
  // R8
  irq_follow_chk: assert property (@(posedge clk) disable iff (rst) 1'b1 |=> (irq == $past(any_src)));
  // R6
  dcd_edge_chk: assert property (@(posedge clk) disable iff (rst) (dcd != $past(dcd)) |=> dcd_chg);
  // R13
  vol_ack_chk: assert property (@(posedge clk) disable iff (rst) vol |-> ack);
endmodule

bind uart_regfile uart_regfile_chk chk_i (
  .clk(clk), .rst(rst), .cyc(cyc), .stb(stb), .we(we), .ack(ack), .vol(vol),
  .tx_push(tx_push), .tx_full(tx_full), .tx_empty(tx_empty), .rx_pop(rx_pop),
  .rx_avail(rx_avail), .irq(irq), .dcd(dcd), .dcd_chg(dcd_chg), .ie_q(ie_q)
);

// File: tb/uart_regfile_tb_top.sv
module uart_regfile_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cyc = 1'b0, stb = 1'b0, we = 1'b0;
  logic [3:0]  adr = '0;
  logic [7:0]  wdat = '0;
  logic [7:0]  rdat;
  logic        ack, vol, irq, tx_push, rx_pop;
  logic [7:0]  tx_data;
  logic        tx_full = 1'b0, tx_empty = 1'b0;
  logic [7:0]  rx_data = '0;
  logic        rx_avail = 1'b0, rx_overrun = 1'b0, rx_frame_err = 1'b0;
  logic        cts = 1'b0, dsr = 1'b0, ri = 1'b0, dcd = 1'b0;
  logic        dtr_o, rts_o, hw_flow_o;
  logic [31:0] mul_o;

  int errors = 0;
  int checks = 0;
  int cycles = 0;

  localparam logic [31:0] MUL_DEF = 32'h0257_C000;

  always #4 clk = ~clk;

  uart_regfile #(.RST_MUL(MUL_DEF)) dut_i (
    .clk(clk), .rst(rst), .cyc(cyc), .stb(stb), .we(we), .adr(adr), .wdat(wdat),
    .rdat(rdat), .ack(ack), .vol(vol), .irq(irq),
    .tx_push(tx_push), .tx_data(tx_data), .tx_full(tx_full), .tx_empty(tx_empty),
    .rx_pop(rx_pop), .rx_data(rx_data), .rx_avail(rx_avail),
    .rx_overrun(rx_overrun), .rx_frame_err(rx_frame_err),
    .cts(cts), .dsr(dsr), .ri(ri), .dcd(dcd),
    .dtr_o(dtr_o), .rts_o(rts_o), .hw_flow_o(hw_flow_o), .mul_o(mul_o)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // one bus access; samples ack-cycle outputs at the negedge after the ack edge
  task automatic access(input logic w, input logic [3:0] a, input logic [7:0] d,
                        output logic [7:0] rd, output logic v, output logic push,
                        output logic pop, output logic ak);
    @(negedge clk);
    cyc = 1'b1; stb = 1'b1; we = w; adr = a; wdat = d;
    @(negedge clk);
    ak = ack; rd = rdat; v = vol; push = tx_push; pop = rx_pop;
    cyc = 1'b0; stb = 1'b0; we = 1'b0;
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    logic [7:0] rd; logic v, p, q, k;
    access(1'b1, a, d, rd, v, p, q, k);
    chk("R2 write ack", {31'b0, k}, 32'd1);
    chk("R13 no vol on write", {31'b0, v}, 32'd0);
  endtask

  task automatic rd_chk(input string tag, input logic [3:0] a, input logic [7:0] exp);
    logic [7:0] rd; logic v, p, q, k;
    access(1'b0, a, 8'h00, rd, v, p, q, k);
    chk("R2 read ack", {31'b0, k}, 32'd1);
    chk(tag, {24'b0, rd}, {24'b0, exp});
    chk("R13 vol", {31'b0, v}, {31'b0, (a <= 4'd2)});
  endtask

  task automatic t_reset();
    chk("R1 ack", {31'b0, ack}, 0);
    chk("R1 irq", {31'b0, irq}, 0);
    chk("R1 push/pop/vol", {29'b0, tx_push, rx_pop, vol}, 0);
    chk("R1 dtr/rts", {30'b0, rts_o, dtr_o}, 32'd3);
    chk("R1 hw_flow", {31'b0, hw_flow_o}, 0);
    chk("R1 mul", mul_o, MUL_DEF);
    rd_chk("R1 ie reset", 4'd4, 8'h00);
  endtask

  task automatic t_handshake();
    // hold strobe for three cycles: ack must toggle, never two high in a row
    @(negedge clk);
    cyc = 1'b1; stb = 1'b1; we = 1'b0; adr = 4'd15;
    @(negedge clk); chk("R2 ack first", {31'b0, ack}, 1);
    @(negedge clk); chk("R2 ack gap", {31'b0, ack}, 0);
    @(negedge clk); chk("R2 ack again", {31'b0, ack}, 1);
    cyc = 1'b0; stb = 1'b0;
    @(negedge clk); chk("R2 ack idle", {31'b0, ack}, 0);
  endtask

  task automatic t_mul();
    wr(4'd8, 8'h11); wr(4'd9, 8'h22); wr(4'd10, 8'h33); wr(4'd11, 8'h44);
    chk("R11 mul order", mul_o, 32'h4433_2211);
    rd_chk("R11 byte1 readback", 4'd9, 8'h22);
    rd_chk("R11 byte3 readback", 4'd11, 8'h44);
  endtask

  task automatic t_storage();
    wr(4'd15, 8'hA5); wr(4'd5, 8'h3C); wr(4'd12, 8'hC3);
    wr(4'd13, 8'hFF); wr(4'd14, 8'hEE);
    rd_chk("R12 scratch", 4'd15, 8'hA5);
    rd_chk("R12 frame", 4'd5, 8'h3C);
    rd_chk("R12 fifo ctl", 4'd12, 8'hC3);
    rd_chk("R12 reserved 13", 4'd13, 8'h00);
    rd_chk("R12 reserved 14", 4'd14, 8'h00);
    chk("R12 outputs untouched", {mul_o}, 32'h4433_2211);
    chk("R12 ctrl outputs untouched", {29'b0, hw_flow_o, rts_o, dtr_o}, 32'd3);
  endtask

  task automatic t_ctrl();
    wr(4'd6, 8'h00);
    chk("R10 dtr/rts low", {30'b0, rts_o, dtr_o}, 0);
    wr(4'd6, 8'hFE);
    chk("R10 rts only", {30'b0, rts_o, dtr_o}, 32'd2);
    rd_chk("R10 mctl readback", 4'd6, 8'h02);
    wr(4'd7, 8'hFF);
    chk("R10 hw_flow", {31'b0, hw_flow_o}, 1);
    rd_chk("R10 ctrl readback", 4'd7, 8'h01);
    wr(4'd4, 8'hFF);
    rd_chk("R9 ie mask", 4'd4, 8'h0B);
    wr(4'd4, 8'h00);
  endtask

  task automatic t_tx();
    logic [7:0] rd; logic v, p, q, k;
    tx_full = 1'b0;
    access(1'b1, 4'd0, 8'h5A, rd, v, p, q, k);
    chk("R3 push", {31'b0, p}, 1);
    chk("R3 tx_data", {24'b0, tx_data}, 32'h5A);
    @(negedge clk); chk("R3 push one cycle", {31'b0, tx_push}, 0);
    tx_full = 1'b1;
    access(1'b1, 4'd0, 8'h77, rd, v, p, q, k);
    chk("R3 drop on full", {31'b0, p}, 0);
    chk("R3 tx_data held", {24'b0, tx_data}, 32'h5A);
    tx_full = 1'b0;
  endtask

  task automatic t_rx();
    logic [7:0] rd; logic v, p, q, k;
    rx_avail = 1'b1; rx_data = 8'h9C;
    access(1'b0, 4'd0, 8'h00, rd, v, p, q, k);
    chk("R4 read data", {24'b0, rd}, 32'h9C);
    chk("R4 pop", {31'b0, q}, 1);
    chk("R13 vol rx", {31'b0, v}, 1);
    rx_avail = 1'b0; rx_data = 8'h11;
    access(1'b0, 4'd0, 8'h00, rd, v, p, q, k);
    chk("R4 empty returns last", {24'b0, rd}, 32'h9C);
    chk("R4 no pop empty", {31'b0, q}, 0);
  endtask

  task automatic t_line();
    rx_avail = 1'b1; rx_overrun = 1'b1; rx_frame_err = 1'b0; tx_full = 1'b0; tx_empty = 1'b1;
    rd_chk("R5 line a", 4'd1, 8'h63);
    rx_avail = 1'b0; rx_overrun = 1'b0; rx_frame_err = 1'b1; tx_full = 1'b1; tx_empty = 1'b0;
    rd_chk("R5 line b", 4'd1, 8'h08);
    rx_frame_err = 1'b0; tx_full = 1'b0;
  endtask

  task automatic t_modem();
    cts = 1'b1; dsr = 1'b0; ri = 1'b1;
    idle(2);
    rd_chk("R6 levels", 4'd2, 8'h50);
    dcd = 1'b1; idle(2);
    rd_chk("R6 change set", 4'd2, 8'hD8);
    wr(4'd2, 8'h00);
    rd_chk("R6 change cleared", 4'd2, 8'hD0);
  endtask

  task automatic t_irq();
    tx_empty = 1'b1; rx_avail = 1'b1; wr(4'd4, 8'h00); idle(2);
    rd_chk("R7 none enabled", 4'd3, 8'h00);
    chk("R8 irq low", {31'b0, irq}, 0);
    rx_avail = 1'b0; wr(4'd4, 8'h02); idle(2);
    rd_chk("R7 tx code", 4'd3, 8'h84);
    chk("R8 irq tx", {31'b0, irq}, 1);
    rx_avail = 1'b1; wr(4'd4, 8'h03); idle(2);
    rd_chk("R7 rx over tx", 4'd3, 8'h88);
    dcd = 1'b0; wr(4'd4, 8'h0B); idle(2);
    rd_chk("R7 modem over rx", 4'd3, 8'h8C);
    chk("R8 irq modem", {31'b0, irq}, 1);
    wr(4'd4, 8'h00); idle(2);
    chk("R8 irq cleared", {31'b0, irq}, 0);
    rx_avail = 1'b0; tx_empty = 1'b0;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=%0d expected<=20000 cycles", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    idle(3);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_handshake();
    t_mul();
    t_storage();
    t_ctrl();
    t_tx();
    t_rx();
    t_line();
    t_modem();
    t_irq();
    idle(2);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule